// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This block is the handshake corner of a serial port. A small control register drives four active-low handshake outputs and holds a loopback switch. A status view shows the live state of four handshake inputs and four sticky change flags. Any set flag can raise an interrupt request, which carries a fixed priority level. The CPU reaches both registers through a one-bit register select, with separate write and read strobes. Reading the status register clears the change flags.

External handshake pins pass through a synchronizer before any change detection. In loopback the block disconnects the outside world. The output pins go idle, the serial output holds the marking level, and the transmit shift output feeds the receive shift input. The status inputs come from the control bits, so software can test the whole handshake path without a cable.

Top module: `mdm_hs_unit`

## Requirements
- R1: Outside loopback, control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n`. A written 1 puts the pin at 0 and a written 0 puts it at 1, from the clock edge that takes the write.
- R2: With `reg_sel`=0, `wr_en` writes the control register and `rdata` returns it. Bit 4 is the loopback enable, and bits 7..5 always read 0 whatever was written.
- R3: In loopback (control bit 4 = 1), `sout` is 1 and `rx_shift_in` equals `tx_shift_out`, while `sin` is ignored. Outside loopback, `sout` equals `tx_shift_out` and `rx_shift_in` equals `sin`.
- R4: In loopback, all four handshake output pins are 1 and the external inputs are ignored. Status takes CTS from control bit 1, DSR from bit 0, RI from bit 2 and DCD from bit 3.
- R5: With `reg_sel`=1, `rdata` bits 4, 5, 6 and 7 show CTS, DSR, RI and DCD as the inverse of their pin levels. A pin change shows there after the second rising clock edge.
- R6: Status bits 0 (CTS), 1 (DSR) and 3 (DCD) become 1 when the matching input changes in either direction, one edge after the change is visible in bits 7..4.
- R7: Status bit 2 becomes 1 only when the RI pin goes from 0 to 1. An RI pin fall leaves it unchanged.
- R8: A read strobe (`rd_en`=1 with `reg_sel`=1) clears status bits 3..0 at the next edge. A change detected at that same edge keeps its bit at 1.
- R9: `irq` is 1 exactly when `ie_modem` is 1 and any of status bits 3..0 is 1, also in loopback. `irq_level` is always 4.
- R10: Reset clears the control register, sets all handshake pins to 1, turns loopback off and clears status bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| wr_en | input | 1 | Write strobe (control only) |
| rd_en | input | 1 | Read strobe; clears change flags when status is selected |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| ie_modem | input | 1 | Handshake interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| sin | input | 1 | Serial input pin |
| sout | output | 1 | Serial output pin |
| tx_shift_out | input | 1 | Bit from the transmit shift path |
| rx_shift_in | output | 1 | Bit toward the receive shift path |
| irq | output | 1 | Handshake interrupt request |
| irq_level | output | 3 | Fixed priority of this request |

## Verification
The assertions assume the CPU strobes are clean, synchronous levels. They also assume `tx_shift_out` and `sin` are synchronous to `clk`. Handshake pins may be asynchronous because they are synchronized inside. The change-flag properties compare each synchronized line with its previous sample, so they need the pins stable across reset. The bench therefore holds every pin high while reset is asserted. It also changes pins and strobes only at the falling clock edge and holds each pin level for at least three edges, so every change reaches the flags before the next read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int unsigned MDM_LINES = 4;
   localparam int unsigned CTRL_W    = 5;

   // Status line order (also the change-flag bit order)
   localparam int unsigned LN_CTS = 0;
   localparam int unsigned LN_DSR = 1;
   localparam int unsigned LN_RI  = 2;
   localparam int unsigned LN_DCD = 3;

   // Control bit positions
   localparam int unsigned CB_DTR  = 0;
   localparam int unsigned CB_RTS  = 1;
   localparam int unsigned CB_OUT1 = 2;
   localparam int unsigned CB_OUT2 = 3;
   localparam int unsigned CB_LOOP = 4;

   typedef struct packed {
      logic dcd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_lines_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 4,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("mdm_sync: at least two stages needed");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
   import mdm_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wdata,
   output logic [CTRL_W-1:0]    ctrl_q,
   output logic                 loop_en,
   output logic [MDM_LINES-1:0] pin_n
);
   initial begin
      assert (DATA_W >= CTRL_W) else $error("mdm_ctrl_reg: data too narrow");
   end

   logic unused_hi;
   assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata[CTRL_W-1:0];
   end

   assign loop_en = ctrl_q[CB_LOOP];

   for (genvar i = 0; i < MDM_LINES; i++) begin : g_pin
      assign pin_n[i] = loop_en ? 1'b1 : ~ctrl_q[i];
   end

   // R1: a normal-mode write shows at the pins after the edge
   p_pin_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[CB_LOOP]) |=> (pin_n == ~$past(wdata[MDM_LINES-1:0])));

   // R4: pins idle while looping
   p_pins_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[CB_LOOP]) |=> (&pin_n));
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int unsigned LINES  = 4,
   parameter int unsigned RI_IDX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] cur,
   input  logic             clr,
   output logic [LINES-1:0] delta_q
);
   initial begin
      assert (RI_IDX < LINES) else $error("mdm_delta: RI index out of range");
   end

   localparam logic [LINES-1:0] BOTH_MASK = ~(LINES'(1) << RI_IDX);

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] hit;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (i == RI_IDX) begin : g_trail
         assign hit[i] = prev_q[i] & ~cur[i];
      end else begin : g_both
         assign hit[i] = prev_q[i] ^ cur[i];
         // R6: any change of a two-edge line sets its flag
         p_both_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cur[i] != prev_q[i]) |=> delta_q[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         delta_q <= '0;
      end else begin
         prev_q  <= cur;
         delta_q <= (delta_q & ~{LINES{clr}}) | hit;
      end
   end

   // R7: RI going active never sets its flag
   p_ri_one_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!prev_q[RI_IDX] && cur[RI_IDX] && !delta_q[RI_IDX]) |=> !delta_q[RI_IDX]);

   // R8: a read with no new change empties the flags
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (cur == prev_q)) |=> (delta_q == '0));

   // R8: a change coinciding with a read survives
   p_keep_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (((cur ^ prev_q) & BOTH_MASK) != '0)) |=> (delta_q != '0));
endmodule

// File: rtl/mdm_hs_unit.sv
module mdm_hs_unit
   import mdm_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEVEL_W     = 3,
   parameter int unsigned IRQ_PRIO    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ie_modem,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              out1_n,
   output logic              out2_n,
   input  logic              sin,
   output logic              sout,
   input  logic              tx_shift_out,
   output logic              rx_shift_in,
   output logic              irq,
   output logic [LEVEL_W-1:0] irq_level
);
   localparam int unsigned STAT_W = 2 * MDM_LINES;

   initial begin
      assert (DATA_W >= STAT_W) else $error("mdm_hs_unit: data narrower than status");
      assert (IRQ_PRIO < (1 << LEVEL_W)) else $error("mdm_hs_unit: level field too narrow");
   end

   logic [CTRL_W-1:0]    ctrl_q;
   logic                 loop_en;
   logic [MDM_LINES-1:0] pin_n;
   mdm_lines_t           pins_raw, pins_sync, act_ext, act_loop, act;
   logic [MDM_LINES-1:0] delta;
   logic                 rd_clr;

   mdm_ctrl_reg #(.DATA_W(DATA_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !reg_sel), .wdata(wdata),
      .ctrl_q(ctrl_q), .loop_en(loop_en), .pin_n(pin_n)
   );

   assign dtr_n  = pin_n[CB_DTR];
   assign rts_n  = pin_n[CB_RTS];
   assign out1_n = pin_n[CB_OUT1];
   assign out2_n = pin_n[CB_OUT2];

   assign pins_raw = '{dcd: dcd_n, ri: ri_n, dsr: dsr_n, cts: cts_n};

   mdm_sync #(.STAGES(SYNC_STAGES), .W(MDM_LINES), .RST_VAL('1)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync)
   );

   assign act_ext  = ~pins_sync;
   assign act_loop = '{dcd: ctrl_q[CB_OUT2], ri: ctrl_q[CB_OUT1],
                       dsr: ctrl_q[CB_DTR],  cts: ctrl_q[CB_RTS]};
   assign act      = loop_en ? act_loop : act_ext;

   assign rd_clr = rd_en && reg_sel;

   mdm_delta #(.LINES(MDM_LINES), .RI_IDX(LN_RI)) i_delta (
      .clk(clk), .rst_n(rst_n), .cur(act), .clr(rd_clr), .delta_q(delta)
   );

   always_comb begin
      rdata = '0;
      if (reg_sel) rdata[STAT_W-1:0] = {act, delta};
      else         rdata[CTRL_W-1:0] = ctrl_q;
   end

   assign sout        = loop_en ? 1'b1 : tx_shift_out;
   assign rx_shift_in = loop_en ? tx_shift_out : sin;

   assign irq       = ie_modem && (|delta);
   assign irq_level = LEVEL_W'(IRQ_PRIO);

   // R3: marking level and internal tap while looping
   p_sout_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (sout && (rx_shift_in == tx_shift_out)));

   // R2: unused control bits never read as 1
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (rdata[DATA_W-1:CTRL_W] == '0));

   // R9: request only with enable and a pending flag
   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie_modem && (rdata[MDM_LINES-1:0] != '0 || !reg_sel)));

   // R4: looping makes all output pins idle
   p_loop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (dtr_n && rts_n && out1_n && out2_n));
endmodule

// File: tb/test_mdm_hs_unit.sv
module test_mdm_hs_unit;
   timeunit 1ns;
   timeprecision 100ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ie_modem = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] pins = 4'b1111; // {dcd_n, ri_n, dsr_n, cts_n}
   logic dtr_n, rts_n, out1_n, out2_n;
   logic sin = 1'b0, tx_shift_out = 1'b0, sout, rx_shift_in, irq;
   logic [2:0] irq_level;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   mdm_hs_unit i_mdm_hs_unit (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .ie_modem(ie_modem),
      .cts_n(pins[0]), .dsr_n(pins[1]), .ri_n(pins[2]), .dcd_n(pins[3]),
      .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
      .sin(sin), .sout(sout), .tx_shift_out(tx_shift_out), .rx_shift_in(rx_shift_in),
      .irq(irq), .irq_level(irq_level)
   );

   // {pins, expected status after three edges}
   localparam logic [11:0] VEC [9] = '{
      {4'b1110, 8'h11}, {4'b1100, 8'h32}, {4'b1000, 8'h70},
      {4'b1100, 8'h34}, {4'b0100, 8'hB8}, {4'b1111, 8'h0B},
      {4'b0110, 8'h99}, {4'b1011, 8'h49}, {4'b1111, 8'h04}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr_ctrl(logic [7:0] v);
      reg_sel = 1'b0; wdata = v; wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(logic sel, output logic [7:0] d);
      reg_sel = sel; rd_en = 1'b1;
      #1 d = rdata;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic peek_stat(output logic [7:0] d);
      reg_sel = 1'b1;
      #1 d = rdata;
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      @(negedge clk); tick(); tick();
      rst_n = 1'b1;
      tick();

      // R10 reset state
      rd(1'b0, d); chk("R10", "ctrl after reset", d, 8'h00);
      rd(1'b1, d); chk("R10", "status after reset", d, 8'h00);
      chk("R10", "pins after reset", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      chk("R9", "irq level", {5'b0, irq_level}, 8'h04);
      sin = 1'b1; tx_shift_out = 1'b0; #1;
      chk("R3", "normal serial path", {6'b0, sout, rx_shift_in}, 8'h01);

      // R5/R6/R7 table walk
      ie_modem = 1'b1;
      foreach (VEC[i]) begin
         pins = VEC[i][11:8];
         tick(); tick(); tick();
         #1;
         chk("R9", "irq vs flags", {7'b0, irq}, {7'b0, |VEC[i][3:0]});
         rd(1'b1, d);
         chk("R6_R7", $sformatf("vector %0d", i), d, VEC[i][7:0]);
      end

      // R5 two-edge latency
      pins = 4'b1101; tick();
      peek_stat(d); chk("R5", "one edge after dsr fall", d, 8'h00);
      tick();
      peek_stat(d); chk("R5", "two edges after dsr fall", d, 8'h20);
      tick();
      rd(1'b1, d); chk("R6", "dsr flag", d, 8'h22);

      // R8 change coinciding with a read
      pins = 4'b1100; tick(); tick();
      rd(1'b1, d); chk("R8", "read at change edge", d, 8'h30);
      rd(1'b1, d); chk("R8", "flag kept", d, 8'h31);
      rd(1'b1, d); chk("R8", "flag cleared", d, 8'h30);

      // R9 enable off
      ie_modem = 1'b0;
      pins = 4'b1111; tick(); tick(); tick(); #1;
      chk("R9", "irq masked", {7'b0, irq}, 8'h00);
      rd(1'b1, d); chk("R6", "flags with irq masked", d, 8'h03);

      // R1 / R2 control
      wr_ctrl(8'h05);
      chk("R1", "pins 0x05", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0A);
      wr_ctrl(8'hEF);
      rd(1'b0, d); chk("R2", "upper bits zero", d, 8'h0F);
      chk("R1", "pins 0x0F", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h00);
      wr_ctrl(8'h00);
      rd(1'b1, d); chk("R10", "no flag from pins", d, 8'h00);

      // R3/R4 loopback
      ie_modem = 1'b1;
      wr_ctrl(8'h13);
      chk("R4", "pins idle in loop", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      tx_shift_out = 1'b0; sin = 1'b1; #1;
      chk("R3", "loop serial lo", {6'b0, sout, rx_shift_in}, 8'h02);
      tx_shift_out = 1'b1; sin = 1'b0; #1;
      chk("R3", "loop serial hi", {6'b0, sout, rx_shift_in}, 8'h03);
      tick();
      rd(1'b1, d); chk("R4", "loop dtr rts", d, 8'h33);
      pins = 4'b0000; tick(); tick(); tick();
      rd(1'b1, d); chk("R4", "external ignored", d, 8'h30);
      pins = 4'b1111; tick(); tick(); tick();
      wr_ctrl(8'h14); tick();
      rd(1'b1, d); chk("R7", "loop ri active no flag", d, 8'h43);
      wr_ctrl(8'h10); tick(); #1;
      chk("R9", "irq in loop", {7'b0, irq}, 8'h01);
      rd(1'b1, d); chk("R7", "loop ri trailing", d, 8'h04);
      wr_ctrl(8'h00); tick();
      rd(1'b1, d); chk("R4", "leave loop quiet", d, 8'h00);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule